// File: doc/BRIEF.md
# Mesh Network Packet Router Node

This block is the packet switch at one node of a rectangular processor mesh. It has six ports: four toward neighbouring nodes (north, south, east, west), one toward the local processor and memory side, and one toward an I/O bridge. Each port has one 16-bit stream in each direction. A packet is always twelve 16-bit beats long: a four-beat header, then a 128-bit payload in eight beats. The router reads the destination coordinates in the first beat of each packet. Packets for other nodes go out a neighbour port with no involvement from the processor. Packets for this node go to the local port or the I/O port.

Routing is dimension-ordered. A packet travels along X until its column matches this node's column, and then along Y. The node's own coordinates are plain static inputs. Every input buffers beats in its own FIFO. Every output is owned by one input for the full length of a packet. When several inputs want the same free output, a round-robin pointer picks the winner.

All streams use valid/ready. A beat moves on a rising clock edge where both valid and ready are high. Once a sender raises valid, it must hold valid and data unchanged until that transfer happens. The router keeps the same rule on its outputs. It never drops a beat: a blocked output fills the FIFO of the input that feeds it, and that input's ready then goes low.

Top module: `mesh_node_router`

## Requirements
- R1: After reset every out_valid bit is 0 and every in_ready bit is 1.
- R2: A packet is 12 beats. Beat 0 holds the destination column in [15:12], the destination row in [11:8], the command in [7:4] and the tag in [3:0]. Beat 1 holds the source column and row in [15:12] and [11:8]. Beats 2 and 3 hold the address, high half first. Beats 4 to 11 hold the payload. The router passes every beat through unchanged and in order.
- R3: Port indices are north 0, south 1, east 2, west 3, local 4, I/O 5. If the destination column is greater than node_x, the packet leaves on east. If it is smaller, the packet leaves on west.
- R4: If the column matches, a destination row greater than node_y sends the packet out south, and a smaller row sends it out north.
- R5: If column and row both match, the packet leaves on the I/O port when command bit 3 (beat 0 bit 7) is 1, and on the local port otherwise. This includes packets that were injected at the local port, which are looped back.
- R6: Once an output shows the first beat of a packet, it carries all 12 beats of that packet with no beats from any other input between them.
- R7: When an output becomes free, the waiting input with the nearest index above the previous owner, counting cyclically, wins it. If inputs keep sending, the grants therefore repeat in a fixed cyclic order.
- R8: Once out_valid is raised, it stays high and out_data stays unchanged until out_ready is seen high.
- R9: Each input buffers FIFO_DEPTH beats (default 16). Its in_ready goes low when its buffer is full. No beat is ever lost or duplicated.
- R10: When one output is blocked, packets from other inputs to other outputs are still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_x | input | 4 | Column of this node |
| node_y | input | 4 | Row of this node (rows grow southward) |
| in_valid | input | 6 | Beat valid per input port |
| in_ready | output | 6 | Input port can accept a beat |
| in_data | input | 96 | Input beats, port p in bits [16p+15:16p] |
| out_valid | output | 6 | Beat valid per output port |
| out_ready | input | 6 | Downstream can accept a beat |
| out_data | output | 96 | Output beats, port p in bits [16p+15:16p] |

## Verification
Each input counts beats modulo twelve, so an error in that count shows on the same cycle as a header that is missing or out of place. A corrupted header makes an output carry a beat that no packet expects there, or makes an output switch source in the middle of a packet. Both are caught at the beat where they happen.

A round-robin pointer that is stuck or skips an input does not change which packets arrive. It only changes the order of packets at a contended output, so it becomes visible once three or more packets compete for that output. An occupancy count that has drifted shows up when a blocked input accepts more or fewer beats than its buffer depth allows. It can also show up as a beat that is lost once the output drains.

// File: rtl/mesh_node_pkg.sv
package mesh_node_pkg;
  localparam int NPORT     = 6;
  localparam int BEAT_W    = 16;
  localparam int PKT_BEATS = 12;
  localparam int IDX_W     = $clog2(NPORT);
  localparam int CNT_W     = $clog2(PKT_BEATS);

  localparam int P_NORTH = 0;
  localparam int P_SOUTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_WEST  = 3;
  localparam int P_LOCAL = 4;
  localparam int P_IO    = 5;

  typedef struct packed {
    logic [3:0] dst_x;
    logic [3:0] dst_y;
    logic [3:0] cmd;
    logic [3:0] tag;
  } lead_beat_t;
endpackage

// File: rtl/mesh_in_fifo.sv
module mesh_in_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  input  logic         pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push;

  assign push_ready = (count < CW'(DEPTH));
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];
  assign push       = push_valid && push_ready;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (!push && pop) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R9: the switch only reads a beat that is really buffered
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);

  // R9: a full buffer refuses data until something leaves
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop) |=> !push_ready);
endmodule

// File: rtl/mesh_route_calc.sv
module mesh_route_calc
  import mesh_node_pkg::*;
(
  input  logic [3:0]       node_x,
  input  logic [3:0]       node_y,
  input  logic [BEAT_W-1:0] lead,
  output logic [NPORT-1:0] route
);
  lead_beat_t h;
  assign h = lead_beat_t'(lead);

  always_comb begin
    route = '0;
    if (h.dst_x > node_x)       route[P_EAST]  = 1'b1;
    else if (h.dst_x < node_x)  route[P_WEST]  = 1'b1;
    else if (h.dst_y > node_y)  route[P_SOUTH] = 1'b1;
    else if (h.dst_y < node_y)  route[P_NORTH] = 1'b1;
    else if (h.cmd[3])          route[P_IO]    = 1'b1;
    else                        route[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/mesh_out_arb.sv
module mesh_out_arb
  import mesh_node_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] src_valid,
  input  logic             hs,
  input  logic             last,
  output logic             valid,
  output logic [IDX_W-1:0] sel
);
  logic             locked;
  logic [IDX_W-1:0] owner, ptr, winner;

  always_comb begin
    int idx;
    logic found;
    winner = '0;
    found  = 1'b0;
    for (int k = 0; k < NPORT; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NPORT) idx = idx - NPORT;
      if (!found && req[idx]) begin
        found  = 1'b1;
        winner = IDX_W'(idx);
      end
    end
  end

  assign sel   = locked ? owner : winner;
  assign valid = locked ? src_valid[owner] : (|req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (!locked) begin
      if (|req) begin
        locked <= 1'b1;
        owner  <= winner;
        ptr    <= (winner == IDX_W'(NPORT - 1)) ? '0 : winner + 1'b1;
      end
    end else if (hs && last) begin
      locked <= 1'b0;
    end
  end

  // R6: ownership does not move until the closing beat has gone
  a_r6_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(hs && last)) |=> (locked && $stable(owner)));

  // R8: a presented beat is not withdrawn
  a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !hs) |=> valid);

  // R7: a free output with a waiting header is claimed next cycle
  a_r7_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && (|req)) |=> locked);
endmodule

// File: rtl/mesh_node_router.sv
module mesh_node_router
  import mesh_node_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                node_x,
  input  logic [3:0]                node_y,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT-1:0]          in_ready,
  input  logic [NPORT*BEAT_W-1:0]   in_data,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT*BEAT_W-1:0]   out_data
);
  logic [NPORT-1:0]  hv;
  logic [BEAT_W-1:0] hd     [NPORT];
  logic [CNT_W-1:0]  cnt    [NPORT];
  logic [NPORT-1:0]  route_v[NPORT];
  logic [NPORT-1:0]  req_o  [NPORT];
  logic [NPORT-1:0]  popm   [NPORT];
  logic [NPORT-1:0]  pop;
  logic [IDX_W-1:0]  sel    [NPORT];
  logic [NPORT-1:0]  hs, last;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    mesh_in_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[i]),
      .push_ready (in_ready[i]),
      .push_data  (in_data[i*BEAT_W +: BEAT_W]),
      .head_valid (hv[i]),
      .head_data  (hd[i]),
      .pop        (pop[i])
    );

    mesh_route_calc u_route (
      .node_x (node_x),
      .node_y (node_y),
      .lead   (hd[i]),
      .route  (route_v[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[i] <= '0;
      else if (pop[i]) cnt[i] <= (cnt[i] == CNT_W'(PKT_BEATS - 1)) ? '0 : cnt[i] + 1'b1;
    end

    assign pop[i] = |popm[i];

    // R9: one beat leaves an input through at most one output
    a_r9_single_reader: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(popm[i]));
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_o[o][i] = hv[i] && (cnt[i] == '0) && route_v[i][o];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        popm[i][o] = hs[o] && (sel[o] == IDX_W'(i));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign hs[o]   = out_valid[o] && out_ready[o];
    assign last[o] = (cnt[sel[o]] == CNT_W'(PKT_BEATS - 1));
    assign out_data[o*BEAT_W +: BEAT_W] = hd[sel[o]];

    mesh_out_arb u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_o[o]),
      .src_valid (hv),
      .hs        (hs[o]),
      .last      (last[o]),
      .valid     (out_valid[o]),
      .sel       (sel[o])
    );

    // R8: a stalled beat keeps its value
    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> $stable(out_data[o*BEAT_W +: BEAT_W]));
  end
endmodule

// File: tb/mesh_node_router_tb.sv
module mesh_node_router_tb;
  localparam int NP = 6;
  localparam int NX = 2;
  localparam int NY = 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0]    in_ready;
  logic [NP*16-1:0] in_data = '0;
  logic [NP-1:0]    out_valid;
  logic [NP-1:0]    out_ready = '1;
  logic [NP*16-1:0] out_data;

  always #5 clk = ~clk;

  mesh_node_router u_dut (
    .clk(clk), .rst_n(rst_n), .node_x(4'(NX)), .node_y(4'(NY)),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef logic [15:0] beat_q_t [$];
  beat_q_t expq [NP][NP];
  int glog [NP][$];
  int cur [NP];
  int bc [NP];
  int acc_cnt [NP];
  logic [NP-1:0] pv = '0, pr = '0;
  logic [15:0] pd [NP];
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_port(int dx, int dy, int cmd);
    if (dx > NX) return 2;      // R3 east
    if (dx < NX) return 3;      // R3 west
    if (dy > NY) return 1;      // R4 south
    if (dy < NY) return 0;      // R4 north
    return cmd[3] ? 5 : 4;      // R5 io / local
  endfunction

  task automatic send_pkt(int p, int dx, int dy, int cmd, int tag);
    logic [15:0] b [12];
    int o;
    bit ok;
    b[0] = {4'(dx), 4'(dy), 4'(cmd), 4'(tag)};
    b[1] = {4'(p), 4'(tag), 8'hA5};
    b[2] = 16'h8000 | 16'(tag);
    b[3] = 16'h0040 | 16'(p);
    for (int k = 4; k < 12; k++) b[k] = {4'(tag), 4'(k), 4'(p), 4'(k + tag)};
    o = exp_port(dx, dy, cmd);
    for (int k = 0; k < 12; k++) expq[p][o].push_back(b[k]);
    for (int k = 0; k < 12; k++) begin
      in_valid[p] = 1'b1;
      in_data[16*p +: 16] = b[k];
      do begin
        #4;
        ok = in_ready[p];
        @(negedge clk);
      end while (!ok);
      acc_cnt[p]++;
    end
    in_valid[p] = 1'b0;
  endtask

  function automatic bit all_idle();
    for (int s = 0; s < NP; s++)
      for (int o = 0; o < NP; o++)
        if (expq[s][o].size() != 0) return 0;
    for (int o = 0; o < NP; o++) if (cur[o] >= 0) return 0;
    return 1;
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (!all_idle() && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  // Reference comparison, sampled just before each rising edge
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        logic [15:0] d, e;
        d = out_data[16*o +: 16];
        if (pv[o] && !pr[o])
          chk(out_valid[o] && d == pd[o], "R8 stalled beat", int'(d), int'(pd[o]));
        if (out_valid[o] && out_ready[o]) begin
          if (cur[o] < 0) begin
            for (int s = 0; s < NP; s++)
              if (cur[o] < 0 && expq[s][o].size() != 0 && expq[s][o][0] == d) cur[o] = s;
            if (cur[o] < 0) chk(0, "R3/R4/R5 unexpected header", int'(d), o);
            else begin
              glog[o].push_back(cur[o]);
              bc[o] = 0;
            end
          end
          if (cur[o] >= 0) begin
            e = expq[cur[o]][o].pop_front();
            chk(d == e, "R2/R6 beat", int'(d), int'(e));
            bc[o]++;
            if (bc[o] == 12) cur[o] = -1;
          end
        end
        pv[o] = out_valid[o];
        pr[o] = out_ready[o];
        pd[o] = d;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int g [$];
    int desc;
    int base;
    for (int o = 0; o < NP; o++) begin
      cur[o] = -1; bc[o] = 0; acc_cnt[o] = 0; pd[o] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready", int'(in_ready), 'h3f);
    @(negedge clk);

    // Routing in every direction, concurrently
    fork
      begin send_pkt(0, 5, 0, 0, 1); send_pkt(0, 2, 1, 8, 6); end
      send_pkt(2, 0, 3, 2, 2);
      send_pkt(3, 2, 3, 3, 3);
      send_pkt(1, 2, 0, 4, 4);
      send_pkt(5, 2, 1, 0, 5);
      send_pkt(4, 2, 1, 1, 7);
    join
    wait_idle();
    chk(expq[0][2].size() == 0, "R3 east delivery", expq[0][2].size(), 0);
    chk(expq[2][3].size() == 0, "R3 west delivery", expq[2][3].size(), 0);
    chk(expq[3][1].size() == 0, "R4 south delivery", expq[3][1].size(), 0);
    chk(expq[1][0].size() == 0, "R4 north delivery", expq[1][0].size(), 0);
    chk(expq[0][5].size() == 0, "R5 io delivery", expq[0][5].size(), 0);
    chk(expq[5][4].size() == 0, "R5 local delivery", expq[5][4].size(), 0);
    chk(expq[4][4].size() == 0, "R5 loopback", expq[4][4].size(), 0);

    // Round robin on the local output
    glog[4].delete();
    fork
      begin send_pkt(0, 2, 1, 0, 1); send_pkt(0, 2, 1, 0, 2); end
      begin send_pkt(1, 2, 1, 0, 3); send_pkt(1, 2, 1, 0, 4); end
      begin send_pkt(3, 2, 1, 0, 5); send_pkt(3, 2, 1, 0, 6); end
    join
    wait_idle();
    g = glog[4];
    chk(g.size() == 6, "R7 grant count", g.size(), 6);
    if (g.size() == 6) begin
      desc = 0;
      if (g[1] < g[0]) desc++;
      if (g[2] < g[1]) desc++;
      if (g[0] < g[2]) desc++;
      chk(g[3] == g[0] && g[4] == g[1] && g[5] == g[2], "R7 repeat order", g[3], g[0]);
      chk(g[0] != g[1] && g[1] != g[2] && g[0] != g[2], "R7 distinct", g[1], g[0]);
      chk(desc == 1, "R7 cyclic ascending", desc, 1);
    end
    chk(all_idle(), "R6 nothing left over", 0, 0);

    // Back-pressure on east, traffic to south unaffected
    out_ready[2] = 1'b0;
    base = acc_cnt[0];
    fork
      begin send_pkt(0, 5, 0, 0, 9); send_pkt(0, 6, 2, 0, 10); end
      begin repeat (3) @(negedge clk); send_pkt(3, 2, 4, 0, 11); end
    join_none
    repeat (40) @(negedge clk);
    #4;
    chk(acc_cnt[0] - base == 16, "R9 beats buffered", acc_cnt[0] - base, 16);
    chk(in_ready[0] == 1'b0, "R9 in_ready low when full", int'(in_ready[0]), 0);
    chk(expq[3][1].size() == 0, "R10 south flows", expq[3][1].size(), 0);
    chk(expq[0][2].size() == 24, "R9 east held", expq[0][2].size(), 24);
    @(negedge clk);
    repeat (40) begin
      out_ready[2] = ~out_ready[2];
      @(negedge clk);
    end
    out_ready[2] = 1'b1;
    wait fork;
    wait_idle();
    chk(acc_cnt[0] - base == 24, "R9 all accepted", acc_cnt[0] - base, 24);
    chk(all_idle(), "R9 no loss", 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule